// File: doc/BRIEF.md
# Shared PLL Enable Sequencer

This block owns the enable of a single PLL and a single supply switch that two PHY ports share. Requesters ask for one of four operations on a PHY port: bring the port up (init), release it (exit), power it, or unpower it. The block keeps an initialized flag and a powered flag for each port. With those flags it reference-counts both resources, so the PLL and the supplies are switched only by the first user to arrive and the last user to leave.

Each change of the PLL enable is followed by a wait counted in clock cycles and by one read of the PLL status input. Only then is the request answered. A full bring-up runs as follows: drop the enable, wait for power-down, pulse a load strobe with the configuration word, raise the enable, wait for lock, and read the status. Two requester channels share one sequencer. Channel 0 wins on a tie, and a channel waiting its turn sees busy.

Requesters hold `req_i` with a stable operation and port index until their `ack_o` bit pulses for one cycle, and they drop the request before the next rising edge.

Top module: `pss_top`

## Requirements
- R1: After reset, `pll_en_o`, `supply_en_o`, `cfg_load_o`, `ack_o` and `err_o` are all low, and both ports are neither initialized nor powered.
- R2: An init request (op code 0) that finds the PLL off, or finds no port initialized, runs the full bring-up. The enable is low for PDN cycles. Then `cfg_load_o` pulses once with `cfg_o` equal to the `cfg_i` seen at grant, and the enable goes high. The ack comes LOCK+1 cycles after the load pulse.
- R3: An init request that finds the enable high and at least one port initialized marks the port initialized and acks in the cycle after grant, without a load pulse and without any change to the enable.
- R4: If `pll_stat_i` is low when the lock wait ends, the init is acked with `err_o`. The port stays uninitialized, so the next init takes the full bring-up path.
- R5: An exit request (op code 1) clears the port's initialized flag. If the other port is still initialized, the block acks in the cycle after grant and leaves the enable high.
- R6: An exit that leaves no port initialized drops the enable, waits PDN cycles and then reads the status. It acks PDN+1 cycles after grant, with `err_o` set if `pll_stat_i` is still high.
- R7: A power-on request (op code 2) raises `supply_en_o`, marks the port powered, and acks in the cycle after grant.
- R8: A power-off request (op code 3) clears the port's powered flag. `supply_en_o` falls only if no port remains powered.
- R9: A request whose port index is 2 or greater is acked with `err_o` in the cycle after grant. It changes no flag, no enable and no supply, and it produces no load pulse.
- R10: Only one request is served at a time, and channel 0 has priority when both channels request together. A channel that holds `req_i` while it is not being served drives its `busy_o` bit high.
- R11: The wait lengths are PDN = ceil(PDN_US*CLK_KHZ/1000) cycles and LOCK = ceil(LOCK_US*CLK_KHZ/1000) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NCH | Request per channel, held until acked |
| op_i | input | 2*NCH | Operation per channel: 0 init, 1 exit, 2 power-on, 3 power-off |
| idx_i | input | IDX_W*NCH | Target PHY port index per channel |
| cfg_i | input | CFG_W | PLL configuration word to load on bring-up |
| pll_stat_i | input | 1 | PLL enable status readback |
| ack_o | output | NCH | One-cycle completion pulse per channel |
| err_o | output | NCH | Error flag, valid with ack_o |
| busy_o | output | NCH | Channel is requesting but not being served |
| pll_en_o | output | 1 | PLL enable |
| cfg_load_o | output | 1 | One-cycle strobe to load cfg_o into the PLL |
| cfg_o | output | CFG_W | Configuration word captured at grant |
| supply_en_o | output | 1 | Combined supply enable |

## Verification
The grant edge is the first rising edge on which the sequencer is idle and the request is present. Counting from that edge, the ack is due 1 cycle later on shortcut and flag-only paths, PDN+1 cycles later on an exit that turns the PLL off, and PDN+LOCK+2 cycles later on a full bring-up. The bench drives requests at falling edges and counts falling edges up to the ack. It compares that count with the latency its own model predicts, so an ack that comes early or late fails the check. The enable, supply and load-pulse count are compared with the model on the same ack falling edge, once every register on the path has settled.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    OP_INIT    = 2'd0,
    OP_EXIT    = 2'd1,
    OP_PWR_ON  = 2'd2,
    OP_PWR_OFF = 2'd3
  } pss_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PDN_WAIT,
    ST_LOAD,
    ST_LOCK_WAIT,
    ST_EXIT_WAIT,
    ST_RESP
  } pss_state_e;

  // whole cycles for a delay in microseconds, rounded up
  function automatic int unsigned us_to_cycles(int unsigned us, int unsigned khz);
    return (us * khz + 999) / 1000;
  endfunction

endpackage

// File: rtl/pss_arbiter.sv
module pss_arbiter #(
  parameter int unsigned NCH  = 2,
  parameter int unsigned CH_W = 1
) (
  input  logic [NCH-1:0]  req_i,
  input  logic            idle_i,
  input  logic [CH_W-1:0] owner_i,
  output logic            gnt_valid_o,
  output logic [CH_W-1:0] gnt_ch_o,
  output logic [NCH-1:0]  busy_o
);

  assign gnt_valid_o = idle_i & (|req_i);

  // lowest index wins
  always_comb begin
    gnt_ch_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_ch_o = CH_W'(i);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_busy
    assign busy_o[c] = req_i[c] & ~(~idle_i & (owner_i == CH_W'(c)));
  end

endmodule

// File: rtl/pss_delay_timer.sv
module pss_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= val_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire_o = run_q & (cnt_q == '0);

  assert_timer_steps_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/pss_seq_core.sv
module pss_seq_core
  import pss_pkg::*;
#(
  parameter int unsigned NCH      = 2,
  parameter int unsigned CH_W     = 1,
  parameter int unsigned NPORT    = 2,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned CFG_W    = 32,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PDN_CYC  = 5,
  parameter int unsigned LOCK_CYC = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_valid_i,
  input  logic [CH_W-1:0]  gnt_ch_i,
  input  pss_op_e          gnt_op_i,
  input  logic [IDX_W-1:0] gnt_idx_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             pll_stat_i,
  input  logic             tmr_expire_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             idle_o,
  output logic [CH_W-1:0]  owner_o,
  output logic [NCH-1:0]   ack_o,
  output logic [NCH-1:0]   err_o,
  output logic             pll_en_o,
  output logic             cfg_load_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             supply_en_o
);

  pss_state_e       state_q, state_d;
  logic [CH_W-1:0]  owner_q, owner_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [NPORT-1:0] init_q, init_d, pwr_q, pwr_d;
  logic             en_q, en_d, sup_q, sup_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [NCH-1:0]   ack_q, ack_d, err_q, err_d;
  logic [NPORT-1:0] req_bit, own_bit, init_left, pwr_left;

  function automatic logic [NPORT-1:0] port_bit(logic [IDX_W-1:0] idx);
    logic [NPORT-1:0] b;
    b = '0;
    for (int i = 0; i < NPORT; i++) if (int'(idx) == i) b[i] = 1'b1;
    return b;
  endfunction

  assign req_bit   = port_bit(gnt_idx_i);
  assign own_bit   = port_bit(idx_q);
  assign init_left = init_q & ~req_bit;
  assign pwr_left  = pwr_q & ~req_bit;

  always_comb begin
    state_d    = state_q;
    owner_d    = owner_q;
    idx_d      = idx_q;
    init_d     = init_q;
    pwr_d      = pwr_q;
    en_d       = en_q;
    sup_d      = sup_q;
    cfg_d      = cfg_q;
    ack_d      = '0;
    err_d      = '0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (gnt_valid_i) begin
          owner_d = gnt_ch_i;
          idx_d   = gnt_idx_i;
          state_d = ST_RESP;
          ack_d[gnt_ch_i] = 1'b1;
          if (int'(gnt_idx_i) >= NPORT) begin
            err_d[gnt_ch_i] = 1'b1;
          end else begin
            unique case (gnt_op_i)
              OP_INIT: begin
                if (en_q && (|init_q)) begin
                  init_d = init_q | req_bit;
                end else begin
                  ack_d      = '0;
                  en_d       = 1'b0;
                  cfg_d      = cfg_i;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = CNT_W'(PDN_CYC - 1);
                  state_d    = ST_PDN_WAIT;
                end
              end
              OP_EXIT: begin
                init_d = init_left;
                if (~|init_left) begin
                  ack_d      = '0;
                  en_d       = 1'b0;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = CNT_W'(PDN_CYC - 1);
                  state_d    = ST_EXIT_WAIT;
                end
              end
              OP_PWR_ON: begin
                pwr_d = pwr_q | req_bit;
                sup_d = 1'b1;
              end
              default: begin
                pwr_d = pwr_left;
                sup_d = |pwr_left;
              end
            endcase
          end
        end
      end
      ST_PDN_WAIT: if (tmr_expire_i) state_d = ST_LOAD;
      ST_LOAD: begin
        en_d       = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(LOCK_CYC - 1);
        state_d    = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        if (tmr_expire_i) begin
          state_d = ST_RESP;
          ack_d[owner_q] = 1'b1;
          if (pll_stat_i) init_d = init_q | own_bit;
          else            err_d[owner_q] = 1'b1;
        end
      end
      ST_EXIT_WAIT: begin
        if (tmr_expire_i) begin
          state_d = ST_RESP;
          ack_d[owner_q] = 1'b1;
          err_d[owner_q] = pll_stat_i;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
      idx_q   <= '0;
      init_q  <= '0;
      pwr_q   <= '0;
      en_q    <= 1'b0;
      sup_q   <= 1'b0;
      cfg_q   <= '0;
      ack_q   <= '0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
      idx_q   <= idx_d;
      init_q  <= init_d;
      pwr_q   <= pwr_d;
      en_q    <= en_d;
      sup_q   <= sup_d;
      cfg_q   <= cfg_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
    end
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign owner_o     = owner_q;
  assign ack_o       = ack_q;
  assign err_o       = err_q;
  assign pll_en_o    = en_q;
  assign cfg_load_o  = (state_q == ST_LOAD);
  assign cfg_o       = cfg_q;
  assign supply_en_o = sup_q;

  assert_load_while_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_o |-> !pll_en_o);
  assert_en_after_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_o |=> pll_en_o);
  assert_init_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|init_q) |-> en_q);
  assert_supply_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_q == (|pwr_q));
  assert_err_only_with_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o & ~ack_o) == '0);
  assert_one_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

endmodule

// File: rtl/pss_top.sv
module pss_top
  import pss_pkg::*;
#(
  parameter int unsigned NCH     = 2,
  parameter int unsigned NPORT   = 2,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned CLK_KHZ = 100000,
  parameter int unsigned PDN_US  = 5,
  parameter int unsigned LOCK_US = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         req_i,
  input  logic [2*NCH-1:0]       op_i,
  input  logic [IDX_W*NCH-1:0]   idx_i,
  input  logic [CFG_W-1:0]       cfg_i,
  input  logic                   pll_stat_i,
  output logic [NCH-1:0]         ack_o,
  output logic [NCH-1:0]         err_o,
  output logic [NCH-1:0]         busy_o,
  output logic                   pll_en_o,
  output logic                   cfg_load_o,
  output logic [CFG_W-1:0]       cfg_o,
  output logic                   supply_en_o
);

  localparam int unsigned CH_W     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned PDN_CYC  = us_to_cycles(PDN_US, CLK_KHZ);
  localparam int unsigned LOCK_CYC = us_to_cycles(LOCK_US, CLK_KHZ);
  localparam int unsigned MAX_CYC  = (PDN_CYC > LOCK_CYC) ? PDN_CYC : LOCK_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             idle, gnt_valid, tmr_load, tmr_expire;
  logic [CH_W-1:0]  gnt_ch, owner;
  logic [CNT_W-1:0] tmr_val;
  pss_op_e          gnt_op;
  logic [IDX_W-1:0] gnt_idx;

  assign gnt_op  = pss_op_e'(op_i[int'(gnt_ch)*2 +: 2]);
  assign gnt_idx = idx_i[int'(gnt_ch)*IDX_W +: IDX_W];

  pss_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .req_i       (req_i),
    .idle_i      (idle),
    .owner_i     (owner),
    .gnt_valid_o (gnt_valid),
    .gnt_ch_o    (gnt_ch),
    .busy_o      (busy_o)
  );

  pss_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expire_o (tmr_expire)
  );

  pss_seq_core #(
    .NCH(NCH), .CH_W(CH_W), .NPORT(NPORT), .IDX_W(IDX_W), .CFG_W(CFG_W),
    .CNT_W(CNT_W), .PDN_CYC(PDN_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gnt_valid_i  (gnt_valid),
    .gnt_ch_i     (gnt_ch),
    .gnt_op_i     (gnt_op),
    .gnt_idx_i    (gnt_idx),
    .cfg_i        (cfg_i),
    .pll_stat_i   (pll_stat_i),
    .tmr_expire_i (tmr_expire),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val),
    .idle_o       (idle),
    .owner_o      (owner),
    .ack_o        (ack_o),
    .err_o        (err_o),
    .pll_en_o     (pll_en_o),
    .cfg_load_o   (cfg_load_o),
    .cfg_o        (cfg_o),
    .supply_en_o  (supply_en_o)
  );

  // a lower-priority grant only when channel 0 is not asking
  assert_prio_ch0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid && gnt_ch != '0) |-> !req_i[0]);

endmodule

// File: tb/pss_top_tb.sv
module pss_top_tb;

  localparam int CLK_KHZ = 2500;
  localparam int PDN     = (5 * CLK_KHZ + 999) / 1000;
  localparam int LOCK    = (100 * CLK_KHZ + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req = '0;
  logic [3:0]  op = '0;
  logic [3:0]  idx = '0;
  logic [31:0] cfg = '0;
  logic        pll_stat;
  logic [1:0]  ack, err, busy;
  logic        pll_en, cfg_load, supply_en;
  logic [31:0] cfg_out;

  logic [2:0]  pipe = '0;
  logic        fail_lock = 1'b0, stuck = 1'b0;
  int          n_chk = 0, n_fail = 0, n_cyc = 0, n_loads = 0;
  logic [31:0] last_cfg = '0;

  logic [1:0]  m_init = '0, m_pwr = '0;
  logic        m_en = 1'b0, m_sup = 1'b0;
  int          m_loads = 0;

  always #5 clk = ~clk;

  pss_top #(.CLK_KHZ(CLK_KHZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .idx_i(idx),
    .cfg_i(cfg), .pll_stat_i(pll_stat), .ack_o(ack), .err_o(err),
    .busy_o(busy), .pll_en_o(pll_en), .cfg_load_o(cfg_load), .cfg_o(cfg_out),
    .supply_en_o(supply_en)
  );

  // PLL model: status follows enable after 3 cycles
  always @(posedge clk) pipe <= {pipe[1:0], pll_en};
  assign pll_stat = fail_lock ? 1'b0 : (stuck ? 1'b1 : pipe[2]);

  always @(negedge clk) begin
    n_cyc++;
    if (cfg_load) begin
      n_loads++;
      last_cfg = cfg_out;
    end
    if (n_cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", n_cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // reference model: predict latency, error and state update
  task automatic model(input int o, input int p, output int lat, output bit e);
    logic [1:0] b;
    b = (p < 2) ? (2'b01 << p) : 2'b00;
    e = 1'b0;
    lat = 1;
    if (p >= 2) e = 1'b1;                                   // R9
    else if (o == 0) begin
      if (!(m_en && (|m_init))) begin                        // R2
        lat = PDN + LOCK + 2; m_en = 1'b1; m_loads++;
        e = fail_lock;                                       // R4
        if (!fail_lock) m_init |= b;
      end else m_init |= b;                                  // R3
    end else if (o == 1) begin
      m_init &= ~b;                                          // R5
      if (m_init == '0) begin lat = PDN + 1; m_en = 1'b0; e = stuck; end  // R6
    end else if (o == 2) begin m_pwr |= b; m_sup = 1'b1; end // R7
    else begin m_pwr &= ~b; m_sup = |m_pwr; end              // R8
  endtask

  task automatic do_req(input int ch, input int o, input int p, input string tag);
    int exp_lat, n;
    bit exp_err;
    model(o, p, exp_lat, exp_err);
    cfg = $urandom;
    req[ch] = 1'b1;
    op[ch*2 +: 2] = 2'(o);
    idx[ch*2 +: 2] = 2'(p);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!ack[ch] && n < 2000);
    chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
    chk(err[ch] == exp_err, {tag, " err"}, int'(err[ch]), int'(exp_err));
    chk(pll_en == m_en, {tag, " pll_en"}, int'(pll_en), int'(m_en));
    chk(supply_en == m_sup, {tag, " supply R7 R8"}, int'(supply_en), int'(m_sup));
    chk(n_loads == m_loads, {tag, " load count"}, n_loads, m_loads);
    if (exp_lat == PDN + LOCK + 2)
      chk(last_cfg == cfg, {tag, " cfg word R2"}, int'(last_cfg), int'(cfg));
    req[ch] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pll_en == 0 && supply_en == 0 && cfg_load == 0 && ack == 0 && err == 0,
        "R1 reset outputs", int'({pll_en, supply_en, cfg_load, ack, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_req(0, 2, 0, "R7 pwr on p0");
    do_req(1, 2, 1, "R7 pwr on p1");
    do_req(0, 3, 0, "R8 pwr off p0 other still on");
    do_req(1, 3, 1, "R8 pwr off last");
    do_req(0, 0, 0, "R2 full init p0");
    do_req(1, 0, 1, "R3 shortcut init p1");
    do_req(0, 1, 0, "R5 exit p0 other on");
    do_req(1, 1, 1, "R6 R11 exit last");
    do_req(0, 0, 2, "R9 bad idx init");
    do_req(1, 2, 3, "R9 bad idx pwr");
    chk(supply_en == 0 && pll_en == 0, "R9 no state change", int'({pll_en, supply_en}), 0);

    // R4 lock failure, then the other port must take the full path
    fail_lock = 1'b1;
    do_req(0, 0, 0, "R4 lock fail");
    fail_lock = 1'b0;
    do_req(1, 0, 1, "R4 full init after fail");
    // R6 status stuck high on last exit
    stuck = 1'b1;
    do_req(1, 1, 1, "R6 exit stuck err");
    stuck = 1'b0;
    repeat (4) @(negedge clk);

    // R10 priority and busy
    req = 2'b11; op = {2'd2, 2'd2}; idx = {2'd1, 2'd0};
    @(negedge clk);
    chk(ack == 2'b01, "R10 ch0 served first", int'(ack), 1);
    chk(busy[1] == 1'b1, "R10 ch1 busy while waiting", int'(busy[1]), 1);
    req[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk(ack == 2'b10, "R10 ch1 served next", int'(ack), 2);
    chk(busy == 2'b00, "R10 no busy when served", int'(busy), 0);
    req[1] = 1'b0;
    m_pwr = 2'b11; m_sup = 1'b1;
    @(negedge clk);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int ch, o, p;
      ch = int'($urandom_range(1, 0));
      o  = int'($urandom_range(3, 0));
      p  = ($urandom_range(7, 0) == 0) ? 3 : int'($urandom_range(1, 0));
      fail_lock = ($urandom_range(7, 0) == 0);
      do_req(ch, o, p, "R2-mix random");
      fail_lock = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule